// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Atomic Set/Clear

This block controls 32 general-purpose pads grouped into two banks of sixteen pins. Each bank keeps its own copy of six per-pin control registers: output value, output enable, input enable, two output auxiliary selects and one input auxiliary select. Each bank also has a read-only pin level view and sticky rising-edge and falling-edge flag registers. Writes to the control registers are atomic. The low half of the 32-bit write word sets bits and the high half clears them, so software can change any group of pins without a read-modify-write.

Pad inputs pass through a two-flop synchronizer. The synchronized level feeds the read-back view and the edge detectors. A pad is driven only while its output enable is set and neither output auxiliary select claims it. Pins 23 and 29 to 31 are reserved and physically inert. Pin 28 is held by a hardware lock mask, so software cannot configure it.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset every control register and every edge flag is 0. All pads are undriven (`pad_oe` and `pad_out` are 0) and every register reads 0.
- R2: Bit 7 of `bus_addr` selects the bank (0: pins 0-15, 1: pins 16-31). Bits 6:0 select the register: 0x00 output value, 0x04 output enable, 0x08 input enable, 0x0C output aux 1, 0x10 output aux 2, 0x14 input aux 1, 0x18 read-back, 0x1C rising flags, 0x20 falling flags. `bus_rdata` is combinational from `bus_addr`, with the bank's per-pin state in bits 15:0 and bits 31:16 always 0.
- R3: For a control register write, a 1 in write bit n (0-15) sets that bank's pin n, taking effect at the write's clock edge.
- R4: For a control register write, a 1 in write bit n+16 clears pin n. Pins with both bits 0 keep their value.
- R5: When the set bit and the clear bit of a pin are both 1 in one write, the pin ends up cleared.
- R6: `pad_oe[i]` is 1 exactly when the pin's output enable is 1 and both of its output aux selects are 0. `pad_out[i]` equals the output value while `pad_oe[i]` is 1 and is 0 otherwise.
- R7: Read-back bit n shows `pad_in` of that pin delayed by two clock edges while its input enable is 1, and shows 0 while input enable is 0.
- R8: A rising or falling transition of the synchronized input sets the matching flag, and the flag stays set until cleared. Writing 1 to low-half bit n of a flag register clears flag n. The high half of such a write has no effect.
- R9: Reserved pins 23, 29, 30 and 31 ignore writes to every register. They read 0 in every register, never set an edge flag and are never driven.
- R10: Pin 28 is locked: writes cannot set any of its control bits, so it reads 0 in those registers and its pad is never driven.
- R11: Writes to the read-back register or to an unmapped offset change nothing. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address; bit 7 picks the bank |
| bus_wdata | input | 32 | Write word (set half / clear half) |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |

## Verification
The bench writes a pin with its set and clear bits both high. A design that lets set win would read that bit back as 1. The bench also samples read-back one and two edges after a pad change, so a synchronizer that is one flop short or long shows up as an early or late bit. It clears edge flags using only the upper half of the write word, and a design that treats flag registers like control registers would lose the flag there. It sets output aux bits on an enabled pin, drives the reserved and locked pins with writes and pad toggles, and reads them back. A design that leaked through either mask would show a driven pad, a nonzero read or a spurious flag.

// File: rtl/gpio_dual_bank_pkg.sv
package gpio_dual_bank_pkg;

    localparam int BANK_W = 16;
    localparam int NUM_SC = 6;

    // indices of the set/clear register cells inside a bank
    localparam int SC_OUT_VAL = 0;
    localparam int SC_OUT_EN  = 1;
    localparam int SC_IN_EN   = 2;
    localparam int SC_OAUX1   = 3;
    localparam int SC_OAUX2   = 4;
    localparam int SC_IAUX1   = 5;

    typedef enum logic [3:0] {
        FR_OUT_VAL  = 4'd0,
        FR_OUT_EN   = 4'd1,
        FR_IN_EN    = 4'd2,
        FR_OAUX1    = 4'd3,
        FR_OAUX2    = 4'd4,
        FR_IAUX1    = 4'd5,
        FR_READBACK = 4'd6,
        FR_POS_EDGE = 4'd7,
        FR_NEG_EDGE = 4'd8,
        FR_NONE     = 4'd15
    } freg_e;

    // word offsets inside a bank; anything else is unmapped
    function automatic freg_e decode_offset(input logic [6:0] off);
        freg_e r;
        r = FR_NONE;
        if (off[1:0] == 2'b00) begin
            case (off[6:2])
                5'd0:    r = FR_OUT_VAL;
                5'd1:    r = FR_OUT_EN;
                5'd2:    r = FR_IN_EN;
                5'd3:    r = FR_OAUX1;
                5'd4:    r = FR_OAUX2;
                5'd5:    r = FR_IAUX1;
                5'd6:    r = FR_READBACK;
                5'd7:    r = FR_POS_EDGE;
                5'd8:    r = FR_NEG_EDGE;
                default: r = FR_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_dual_bank_screg.sv
module gpio_dual_bank_screg #(
    parameter int             W     = 16,
    parameter logic [W-1:0]   WMASK = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);

    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;

    assign set_m = set_bits & WMASK;
    assign clr_m = clr_bits & WMASK;

    // clear is applied after set, so clear wins on a collision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= (q | set_m) & ~clr_m;
        end
    end

endmodule

// File: rtl/gpio_dual_bank_sync_edge.sv
module gpio_dual_bank_sync_edge #(
    parameter int           W    = 16,
    parameter logic [W-1:0] LIVE = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    input  logic         clr_pos,
    input  logic         clr_neg,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] level,
    output logic [W-1:0] pos_flag,
    output logic [W-1:0] neg_flag
);

    logic [W-1:0] sync_a;
    logic [W-1:0] sync_b;
    logic [W-1:0] sync_prev;
    logic [W-1:0] rise;
    logic [W-1:0] fall;
    logic [W-1:0] pos_keep;
    logic [W-1:0] neg_keep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a    <= '0;
            sync_b    <= '0;
            sync_prev <= '0;
        end else begin
            sync_a    <= pad_in;
            sync_b    <= sync_a;
            sync_prev <= sync_b;
        end
    end

    assign level    = sync_b & LIVE;
    assign rise     = sync_b & ~sync_prev & LIVE;
    assign fall     = ~sync_b & sync_prev & LIVE;
    assign pos_keep = clr_pos ? ~clr_bits : {W{1'b1}};
    assign neg_keep = clr_neg ? ~clr_bits : {W{1'b1}};

    // a new edge in the clearing cycle is kept, so no event is lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_flag <= '0;
            neg_flag <= '0;
        end else begin
            pos_flag <= (pos_flag & pos_keep) | rise;
            neg_flag <= (neg_flag & neg_keep) | fall;
        end
    end

endmodule

// File: rtl/gpio_dual_bank_bank.sv
module gpio_dual_bank_bank
    import gpio_dual_bank_pkg::*;
#(
    parameter int           W     = 16,
    parameter logic [W-1:0] WMASK = {W{1'b1}},
    parameter logic [W-1:0] LIVE  = {W{1'b1}}
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  freg_e          sel,
    input  logic [2*W-1:0] wdata,
    input  logic [W-1:0]   pad_in,
    output logic [W-1:0]   pad_out,
    output logic [W-1:0]   pad_oe,
    output logic [2*W-1:0] rdata
);

    logic [W-1:0] q [NUM_SC];
    logic [W-1:0] level;
    logic [W-1:0] pos_flag;
    logic [W-1:0] neg_flag;
    logic [W-1:0] readback;
    logic [W-1:0] rd_val;

    for (genvar k = 0; k < NUM_SC; k++) begin : g_cell
        gpio_dual_bank_screg #(
            .W     (W),
            .WMASK (WMASK)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr && (sel == freg_e'(k))),
            .set_bits (wdata[W-1:0]),
            .clr_bits (wdata[2*W-1:W]),
            .q        (q[k])
        );
    end

    gpio_dual_bank_sync_edge #(
        .W    (W),
        .LIVE (LIVE)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .clr_pos  (wr && (sel == FR_POS_EDGE)),
        .clr_neg  (wr && (sel == FR_NEG_EDGE)),
        .clr_bits (wdata[W-1:0]),
        .level    (level),
        .pos_flag (pos_flag),
        .neg_flag (neg_flag)
    );

    assign readback = level & q[SC_IN_EN];
    assign pad_oe   = q[SC_OUT_EN] & ~q[SC_OAUX1] & ~q[SC_OAUX2];
    assign pad_out  = q[SC_OUT_VAL] & pad_oe;

    always_comb begin
        rd_val = '0;
        case (sel)
            FR_OUT_VAL:  rd_val = q[SC_OUT_VAL];
            FR_OUT_EN:   rd_val = q[SC_OUT_EN];
            FR_IN_EN:    rd_val = q[SC_IN_EN];
            FR_OAUX1:    rd_val = q[SC_OAUX1];
            FR_OAUX2:    rd_val = q[SC_OAUX2];
            FR_IAUX1:    rd_val = q[SC_IAUX1];
            FR_READBACK: rd_val = readback;
            FR_POS_EDGE: rd_val = pos_flag;
            FR_NEG_EDGE: rd_val = neg_flag;
            default:     rd_val = '0;
        endcase
    end

    assign rdata = {{W{1'b0}}, rd_val};

endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
    import gpio_dual_bank_pkg::*;
#(
    parameter int                  NUM_PINS  = 32,
    parameter int                  ADDR_W    = 8,
    parameter logic [NUM_PINS-1:0] RSVD_MASK = 32'hE080_0000,
    parameter logic [NUM_PINS-1:0] LOCK_MASK = 32'h1000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2*BANK_W-1:0] bus_wdata,
    input  logic                bus_we,
    output logic [2*BANK_W-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    localparam int NUM_BANKS = NUM_PINS / BANK_W;
    localparam int BSEL_W    = $clog2(NUM_BANKS);
    localparam int OFF_W     = ADDR_W - BSEL_W;
    localparam int DATA_W    = 2 * BANK_W;
    localparam logic [NUM_PINS-1:0] WMASK_ALL = ~(RSVD_MASK | LOCK_MASK);
    localparam logic [NUM_PINS-1:0] LIVE_ALL  = ~RSVD_MASK;

    logic [BSEL_W-1:0] bank_sel;
    logic [OFF_W-1:0]  offset;
    freg_e             sel;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];

    assign bank_sel = bus_addr[ADDR_W-1 -: BSEL_W];
    assign offset   = bus_addr[OFF_W-1:0];
    assign sel      = decode_offset(offset);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_dual_bank_bank #(
            .W     (BANK_W),
            .WMASK (WMASK_ALL[b*BANK_W +: BANK_W]),
            .LIVE  (LIVE_ALL[b*BANK_W +: BANK_W])
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (bus_we && (bank_sel == BSEL_W'(b))),
            .sel     (sel),
            .wdata   (bus_wdata),
            .pad_in  (pad_in[b*BANK_W +: BANK_W]),
            .pad_out (pad_out[b*BANK_W +: BANK_W]),
            .pad_oe  (pad_oe[b*BANK_W +: BANK_W]),
            .rdata   (bank_rd[b])
        );
    end

    assign bus_rdata = bank_rd[bank_sel];

endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk #(
    parameter logic [31:0] RSVD_MASK = 32'hE080_0000,
    parameter logic [31:0] LOCK_MASK = 32'h1000_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        hi_bank,
    input logic        bus_we,
    input logic [31:0] bus_rdata,
    input logic [31:0] pad_out,
    input logic [31:0] pad_oe
);

    // R1: pads stay released while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (pad_oe == '0 && pad_out == '0);
        end
    end

    // R2: upper half of read data is always zero
    a_r2_rdata_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0);

    // R6: a pad never shows a high level while it is not driven
    a_r6_out_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    // R6: pad drive only moves after a bus write
    a_r6_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pad_oe) |-> $past(bus_we));

    // R9: reserved pads are never driven
    a_r9_rsvd_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & RSVD_MASK) == '0);

    // R9: reserved bits of the high bank read zero
    a_r9_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hi_bank |-> ((bus_rdata[15:0] & RSVD_MASK[31:16]) == 16'h0));

    // R10: the locked pad is never driven
    a_r10_locked_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & LOCK_MASK) == '0);

endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(
    .RSVD_MASK (RSVD_MASK),
    .LOCK_MASK (LOCK_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_bank   (bus_addr[ADDR_W-1]),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_dual_bank_test.sv
`timescale 1ns/1ps
module gpio_dual_bank_test;

    localparam time CYC = 20ns;
    localparam int  NV  = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = 32'h0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CYC/2) clk = ~clk;

    gpio_dual_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    // {req number, address, write word, expected read of the same address}
    localparam logic [79:0] VEC [NV] = '{
        {8'd3,  8'h00, 32'h0000_00A5, 32'h0000_00A5},  // R3 set pattern
        {8'd3,  8'h00, 32'h0000_0F00, 32'h0000_0FA5},  // R3 set adds to earlier bits
        {8'd4,  8'h00, 32'h0005_0000, 32'h0000_0FA0},  // R4 clear bits 0 and 2
        {8'd5,  8'h00, 32'h0101_0101, 32'h0000_0EA0},  // R5 set+clear on bits 0 and 8
        {8'd4,  8'h00, 32'h0000_0000, 32'h0000_0EA0},  // R4 empty write keeps state
        {8'd9,  8'h80, 32'h0000_FFFF, 32'h0000_0F7F},  // R9 R10 high bank masked set
        {8'd4,  8'h80, 32'h00FF_0000, 32'h0000_0F00},  // R4 high bank clear
        {8'd2,  8'h04, 32'h0000_0003, 32'h0000_0003},  // R2 output enable offset
        {8'd2,  8'h08, 32'h0000_FFFF, 32'h0000_FFFF},  // R2 input enable offset
        {8'd2,  8'h0C, 32'h0000_0002, 32'h0000_0002},  // R2 output aux 1 offset
        {8'd11, 8'h18, 32'h0000_FFFF, 32'h0000_0000},  // R11 read-back ignores writes
        {8'd11, 8'h24, 32'h0000_FFFF, 32'h0000_0000},  // R11 unmapped offset
        {8'd9,  8'h84, 32'h0000_FFFF, 32'h0000_0F7F},  // R9 high output enable masked
        {8'd9,  8'h88, 32'h0000_FFFF, 32'h0000_0F7F}   // R9 high input enable masked
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CYC * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        #5 rst_n = 1'b0;
        wait_cyc(3);
        // R1 reset state
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        rst_n = 1'b1;
        wait_cyc(1);
        for (int a = 0; a < 9; a++) begin
            rd(8'(a * 4), d);
            check("R1 low bank reg", d, 32'h0);
            rd(8'(8'h80 + a * 4), d);
            check("R1 high bank reg", d, 32'h0);
        end

        // vector table
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], d);
            total++;
            if (d !== VEC[i][31:0]) begin
                bad++;
                $display("FAIL R%0d vector %0d: got %08h expected %08h",
                         VEC[i][79:72], i, d, VEC[i][31:0]);
            end
        end

        // R6 pad drive with output aux claiming pin 1
        check("R6 pad_oe aux1", pad_oe, 32'h0F7F_0001);
        check("R6 pad_out", pad_out, 32'h0F00_0000);
        wr(8'h00, 32'h0000_0001);
        check("R6 pad_out pin0", pad_out, 32'h0F00_0001);
        wr(8'h0C, 32'h0002_0000);
        check("R6 pad_oe aux1 released", pad_oe, 32'h0F7F_0003);
        wr(8'h10, 32'h0000_0001);
        check("R6 pad_oe aux2", pad_oe, 32'h0F7F_0002);
        check("R6 pad_out aux2", pad_out, 32'h0F00_0000);

        // R10 locked pin 28
        wr(8'h80, 32'h0000_1000);
        rd(8'h80, d);
        check("R10 locked set", d, 32'h0000_0F00);
        check("R10 locked pad", pad_out & 32'h1000_0000, 32'h0);

        // R7 synchronizer depth and input enable
        rd(8'h18, d);
        @(negedge clk);
        pad_in[5] = 1'b1;
        @(negedge clk);
        rd(8'h18, d);
        check("R7 one edge", d, 32'h0);
        @(negedge clk);
        rd(8'h18, d);
        check("R7 two edges", d, 32'h0000_0020);
        wr(8'h08, 32'h0020_0000);
        rd(8'h18, d);
        check("R7 input disabled", d, 32'h0);

        // R8 edge flags
        wait_cyc(2);
        rd(8'h1C, d);
        check("R8 rise flag", d, 32'h0000_0020);
        rd(8'h20, d);
        check("R8 no fall flag", d, 32'h0);
        pad_in[5] = 1'b0;
        wait_cyc(4);
        rd(8'h20, d);
        check("R8 fall flag", d, 32'h0000_0020);
        wr(8'h1C, 32'hFFFF_0000);
        rd(8'h1C, d);
        check("R8 high half no clear", d, 32'h0000_0020);
        wr(8'h1C, 32'h0000_0020);
        rd(8'h1C, d);
        check("R8 flag cleared", d, 32'h0);
        rd(8'h20, d);
        check("R8 other flag kept", d, 32'h0000_0020);
        wait_cyc(3);
        rd(8'h1C, d);
        check("R8 flag stays clear", d, 32'h0);

        // R9 reserved pins do not flag or read back
        @(negedge clk);
        pad_in[31] = 1'b1;
        pad_in[23] = 1'b1;
        pad_in[16] = 1'b1;
        wait_cyc(5);
        rd(8'h9C, d);
        check("R9 high rise flags", d, 32'h0000_0001);
        rd(8'h98, d);
        check("R9 high read-back", d, 32'h0000_0001);

        // R1 reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(2);
        check("R1 mid reset pad_oe", pad_oe, 32'h0);
        rst_n = 1'b1;
        pad_in = 32'h0;
        wait_cyc(1);
        rd(8'h00, d);
        check("R1 mid reset value", d, 32'h0);
        rd(8'h9C, d);
        check("R1 mid reset flags", d, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule